// File: doc/BRIEF.md
# UART Receive Character Buffer with Error Status

This block sits between the bit-level receive deserializer of a UART and the processor bus. Each finished character arrives on a one-cycle strobe together with its data byte and three error tags: parity, framing and break. The block stores up to three characters in a holding queue. A fourth character can wait in a single shift stage, so four characters are buffered in total before data is lost. The processor sees the oldest character on the read-data port and removes it with a buffer-read strobe.

The error view has two modes. In per-character mode it shows the tags of the oldest stored character. In block mode it shows the OR of the tags of every character that has reached the head of the queue since the last error-clear command. An overrun flag records a character lost in the shift stage. A request output follows either the not-empty or the full condition, as chosen by a select bit. An optional automatic RTS output tells the remote transmitter to stop while no slot is free. Enable, disable and receiver-reset commands control whether new characters are accepted.

Top module: `rx_char_buffer`

## Requirements
- R1: After `rst_n` low, `ready`, `full`, `overrun`, `req` and all three error outputs are 0, `rts` is 1, and the receiver is off. In that state a `char_done` strobe is not stored until a `cmd_enable` pulse is seen.
- R2: Characters leave in arrival order. `rd_data` shows the oldest stored byte while `ready` is 1, and each `buf_rd` pulse removes exactly one character.
- R3: `ready` is 1 when at least one character is stored, and `full` is 1 when all three holding slots are occupied. Both update on the clock edge that samples the push or pop.
- R4: A character that arrives while the three slots are full waits in the shift stage. It enters the queue on the same edge at which a `buf_rd` frees a slot, so `full` stays 1 after that pop.
- R5: A character that arrives while the shift stage already holds one overwrites it and leaves the queue unchanged. A `start_det` pulse while the shift stage is occupied sets `overrun` on that edge. `overrun` stays set until `err_clr` or `rx_rst`.
- R6: With `block_mode` 0, `st_pe` (bit 0), `st_fe` (bit 1) and `st_rb` (bit 2) equal the tags of the oldest stored character, and all three are 0 when nothing is stored.
- R7: With `block_mode` 1, each error output is the OR of that tag over every character that has been at the head of the queue since the last `err_clr`. An `err_clr` pulse restarts the accumulation from the character currently at the head, if any.
- R8: `req` equals `full` when `irq_sel_full` is 1 and equals `ready` when it is 0.
- R9: With `auto_rts` 1, a `start_det` pulse while `full` is 1 drives `rts` to 0 on the next edge. `rts` returns to 1 one edge after the count drops below three. With `auto_rts` 0, `rts` is 1.
- R10: After `cmd_disable`, `char_done` strobes are ignored, and neither the queue nor the shift stage takes them. `buf_rd` still removes stored characters.
- R11: A `buf_rd` pulse while nothing is stored changes no output.
- R12: An `rx_rst` pulse empties the queue and the shift stage, clears `overrun`, the block accumulation and `req`, sets `rts` to 1, and turns the receiver off until the next `cmd_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_enable | input | 1 | Pulse: start accepting characters |
| cmd_disable | input | 1 | Pulse: stop accepting characters |
| rx_rst | input | 1 | Pulse: receiver reset |
| char_done | input | 1 | Pulse: a character has been assembled |
| char_data | input | DW | Data byte of the finished character |
| char_pe | input | 1 | Parity error tag of the finished character |
| char_fe | input | 1 | Framing error tag of the finished character |
| char_rb | input | 1 | Break tag of the finished character |
| start_det | input | 1 | Pulse: valid start bit detected |
| buf_rd | input | 1 | Pulse: processor reads and removes the oldest character |
| err_clr | input | 1 | Pulse: clear error status and overrun |
| block_mode | input | 1 | 1 selects accumulated error status |
| irq_sel_full | input | 1 | 1 makes the request follow full, 0 follows ready |
| auto_rts | input | 1 | Enables automatic RTS control |
| rd_data | output | DW | Oldest stored byte |
| ready | output | 1 | At least one character stored |
| full | output | 1 | All holding slots occupied |
| st_pe | output | 1 | Parity error status |
| st_fe | output | 1 | Framing error status |
| st_rb | output | 1 | Break status |
| overrun | output | 1 | Sticky overrun flag |
| req | output | 1 | Interrupt or DMA request |
| rts | output | 1 | Request-to-send, 1 means send allowed |

## Verification
The assertions assume that every command and strobe input is a single-cycle pulse. They also assume that `cmd_enable` and `cmd_disable` are never raised together, and that `start_det` never coincides with `buf_rd`, so the overrun and RTS conditions are judged against a queue that is not moving in the same cycle. The stimulus drives each pulse for exactly one clock, a short time after a rising edge, and keeps those pairs apart. It also keeps `block_mode`, `irq_sel_full` and `auto_rts` steady across any edge where their effect is checked.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  // error tag vector: bit 0 parity, bit 1 framing, bit 2 break
  typedef logic [2:0] rx_err_t;
  localparam int EB_PE = 0;
  localparam int EB_FE = 1;
  localparam int EB_RB = 2;

  // circular index advance for a depth that need not be a power of two
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

  // occupancy after one optional push and one optional pop
  function automatic int unsigned occ_next(input int unsigned occ, input logic push, input logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 push,
  input  logic                 pop,
  input  logic [DW-1:0]        wr_data,
  input  rxb_pkg::rx_err_t     wr_err,
  output logic [DW-1:0]        top_data,
  output rxb_pkg::rx_err_t     top_err,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                 empty,
  output logic                 is_full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem_d [DEPTH];
  rxb_pkg::rx_err_t mem_e [DEPTH];
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    cnt;

  // named internal events
  logic pop_ok, push_ok;
  assign empty   = (cnt == '0);
  assign is_full = (cnt == CW'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!is_full || pop_ok);

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_d[wr_ptr] <= wr_data;
      mem_e[wr_ptr] <= wr_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (pop_ok)  rd_ptr <= PW'(rxb_pkg::wrap_inc(int'(rd_ptr), DEPTH));
      if (push_ok) wr_ptr <= PW'(rxb_pkg::wrap_inc(int'(wr_ptr), DEPTH));
      cnt <= CW'(rxb_pkg::occ_next(int'(cnt), push_ok, pop_ok));
    end
  end

  assign top_data = mem_d[rd_ptr];
  assign top_err  = mem_e[rd_ptr];
  assign count    = cnt;

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clr) |=> $stable(cnt));

  p_fifo_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push && !clr) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rxb_err.sv
module rxb_err (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             err_clr,
  input  logic             block_mode,
  input  logic             top_valid,
  input  rxb_pkg::rx_err_t top_err,
  input  logic             ovr_evt,
  output rxb_pkg::rx_err_t st_err,
  output logic             overrun
);
  rxb_pkg::rx_err_t acc, cur;
  logic             ovr_q;

  assign cur    = top_valid ? top_err : '0;
  assign st_err = block_mode ? (acc | cur) : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acc <= '0;
    else if (clr || err_clr)   acc <= '0;
    else                       acc <= acc | cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovr_q <= 1'b0;
    else if (clr)      ovr_q <= 1'b0;
    else if (ovr_evt)  ovr_q <= 1'b1;
    else if (err_clr)  ovr_q <= 1'b0;
  end
  assign overrun = ovr_q;

  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clr && !clr) |=> overrun);

  p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !clr) |=> overrun);

  p_block_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (block_mode && !err_clr && !clr) |=>
      (!block_mode || ((st_err & $past(st_err)) == $past(st_err))));

  p_char_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!block_mode && !top_valid) |-> (st_err == '0));
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_enable,
  input  logic          cmd_disable,
  input  logic          rx_rst,
  input  logic          char_done,
  input  logic [DW-1:0] char_data,
  input  logic          char_pe,
  input  logic          char_fe,
  input  logic          char_rb,
  input  logic          start_det,
  input  logic          buf_rd,
  input  logic          err_clr,
  input  logic          block_mode,
  input  logic          irq_sel_full,
  input  logic          auto_rts,
  output logic [DW-1:0] rd_data,
  output logic          ready,
  output logic          full,
  output logic          st_pe,
  output logic          st_fe,
  output logic          st_rb,
  output logic          overrun,
  output logic          req,
  output logic          rts
);
  localparam int CW = $clog2(DEPTH + 1);

  logic             rx_on, hold_v, rts_q;
  logic [DW-1:0]    hold_d;
  rxb_pkg::rx_err_t hold_e, new_e, top_e, st_e;
  logic [CW-1:0]    occ;
  logic             q_empty, q_full;

  // named internal events
  logic acc_ev, pop_ev, move_ev, new_to_q, to_hold, ovr_ev, rts_drop, push_q;
  logic [DW-1:0]    push_d;
  rxb_pkg::rx_err_t push_e;

  assign new_e    = {char_rb, char_fe, char_pe};
  assign acc_ev   = char_done && rx_on;
  assign pop_ev   = buf_rd && !q_empty;
  assign move_ev  = hold_v && pop_ev;
  assign new_to_q = acc_ev && !hold_v && (!q_full || pop_ev);
  assign to_hold  = acc_ev && (hold_v || (q_full && !pop_ev));
  assign ovr_ev   = start_det && rx_on && hold_v && !pop_ev;
  assign rts_drop = auto_rts && start_det && rx_on && q_full;
  assign push_q   = move_ev || new_to_q;
  assign push_d   = move_ev ? hold_d : char_data;
  assign push_e   = move_ev ? hold_e : new_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rx_on <= 1'b0;
    else if (rx_rst)      rx_on <= 1'b0;
    else if (cmd_enable)  rx_on <= 1'b1;
    else if (cmd_disable) rx_on <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hold_v <= 1'b0;
    else if (rx_rst)      hold_v <= 1'b0;
    else if (to_hold)     hold_v <= 1'b1;
    else if (move_ev)     hold_v <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (to_hold) begin
      hold_d <= char_data;
      hold_e <= new_e;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rts_q <= 1'b1;
    else if (rx_rst)      rts_q <= 1'b1;
    else if (!auto_rts)   rts_q <= 1'b1;
    else if (rts_drop)    rts_q <= 1'b0;
    else if (!q_full)     rts_q <= 1'b1;
  end

  rxb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rx_rst),
    .push(push_q), .pop(pop_ev),
    .wr_data(push_d), .wr_err(push_e),
    .top_data(rd_data), .top_err(top_e),
    .count(occ), .empty(q_empty), .is_full(q_full)
  );

  rxb_err u_err (
    .clk(clk), .rst_n(rst_n), .clr(rx_rst), .err_clr(err_clr),
    .block_mode(block_mode), .top_valid(!q_empty), .top_err(top_e),
    .ovr_evt(ovr_ev), .st_err(st_e), .overrun(overrun)
  );

  assign ready = !q_empty;
  assign full  = q_full;
  assign st_pe = st_e[rxb_pkg::EB_PE];
  assign st_fe = st_e[rxb_pkg::EB_FE];
  assign st_rb = st_e[rxb_pkg::EB_RB];
  assign req   = irq_sel_full ? q_full : !q_empty;
  assign rts   = rts_q;

  p_hold_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> q_full);

  p_move_keeps_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (move_ev && !rx_rst) |=> full);

  p_rts_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_drop && !rx_rst) |=> !rts);

  p_off_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && char_done && !buf_rd && !rx_rst) |=> $stable(occ));

  p_rx_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> (!ready && !overrun && rts && !req));
endmodule

// File: tb/sim_rx_char_buffer.sv
module sim_rx_char_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_enable = 0, cmd_disable = 0, rx_rst = 0, char_done = 0;
  logic [7:0] char_data = '0;
  logic char_pe = 0, char_fe = 0, char_rb = 0, start_det = 0, buf_rd = 0, err_clr = 0;
  logic block_mode = 0, irq_sel_full = 0, auto_rts = 0;
  logic [7:0] rd_data;
  logic ready, full, st_pe, st_fe, st_rb, overrun, req, rts;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_char_buffer u0 (
    .clk(clk), .rst_n(rst_n), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .rx_rst(rx_rst), .char_done(char_done), .char_data(char_data),
    .char_pe(char_pe), .char_fe(char_fe), .char_rb(char_rb),
    .start_det(start_det), .buf_rd(buf_rd), .err_clr(err_clr),
    .block_mode(block_mode), .irq_sel_full(irq_sel_full), .auto_rts(auto_rts),
    .rd_data(rd_data), .ready(ready), .full(full), .st_pe(st_pe), .st_fe(st_fe),
    .st_rb(st_rb), .overrun(overrun), .req(req), .rts(rts)
  );

  // op(1: pop, 0: push), data, expected ready, expected full, expected head byte
  localparam logic [18:0] VEC [0:10] = '{
    {1'b0, 8'hA1, 1'b1, 1'b0, 8'hA1},
    {1'b0, 8'hB2, 1'b1, 1'b0, 8'hA1},
    {1'b1, 8'h00, 1'b1, 1'b0, 8'hB2},
    {1'b0, 8'hC3, 1'b1, 1'b0, 8'hB2},
    {1'b0, 8'hD4, 1'b1, 1'b1, 8'hB2},
    {1'b1, 8'h00, 1'b1, 1'b0, 8'hC3},
    {1'b1, 8'h00, 1'b1, 1'b0, 8'hD4},
    {1'b1, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b0, 8'h5E, 1'b1, 1'b0, 8'h5E},
    {1'b1, 8'h00, 1'b0, 1'b0, 8'h00}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic pe, input logic fe, input logic rb);
    char_done = 1; char_data = d; char_pe = pe; char_fe = fe; char_rb = rb;
    tick();
    char_done = 0; char_pe = 0; char_fe = 0; char_rb = 0;
  endtask

  task automatic pop();
    buf_rd = 1; tick(); buf_rd = 0;
  endtask

  task automatic pulse_start();
    start_det = 1; tick(); start_det = 0;
  endtask

  task automatic pulse_clr();
    err_clr = 1; tick(); err_clr = 0;
  endtask

  task automatic enable();
    cmd_enable = 1; tick(); cmd_enable = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 ready", {7'd0, ready}, 8'd0);
    chk("R1 full", {7'd0, full}, 8'd0);
    chk("R1 overrun", {7'd0, overrun}, 8'd0);
    chk("R1 rts", {7'd0, rts}, 8'd1);
    chk("R1 req", {7'd0, req}, 8'd0);
    chk("R1 flags", {5'd0, st_rb, st_fe, st_pe}, 8'd0);
    push(8'h5A, 0, 0, 0);
    chk("R1 off ignores char", {7'd0, ready}, 8'd0);
    enable();

    // R2 R3 table walk
    for (int i = 0; i < 11; i++) begin
      if (VEC[i][18]) pop(); else push(VEC[i][17:10], 0, 0, 0);
      chk("R3 ready", {7'd0, ready}, {7'd0, VEC[i][9]});
      chk("R3 full", {7'd0, full}, {7'd0, VEC[i][8]});
      if (VEC[i][9]) chk("R2 head", rd_data, VEC[i][7:0]);
    end

    // R11 pop of empty store
    pop();
    chk("R11 ready", {7'd0, ready}, 8'd0);
    chk("R11 overrun", {7'd0, overrun}, 8'd0);

    // R4 shift stage waits, then moves on pop
    push(8'h11, 0, 0, 0); push(8'h22, 0, 0, 0); push(8'h33, 0, 0, 0);
    push(8'h44, 0, 0, 0);
    chk("R4 full", {7'd0, full}, 8'd1);
    chk("R4 head", rd_data, 8'h11);
    pop();
    chk("R4 full after move", {7'd0, full}, 8'd1);
    chk("R4 head", rd_data, 8'h22);
    pop();
    chk("R4 full", {7'd0, full}, 8'd0);
    chk("R4 head", rd_data, 8'h33);
    pop();
    chk("R4 waited char", rd_data, 8'h44);
    pop();
    chk("R4 empty", {7'd0, ready}, 8'd0);

    // R5 overrun
    push(8'hAA, 0, 0, 0); push(8'hBB, 0, 0, 0); push(8'hCC, 0, 0, 0);
    push(8'hDD, 0, 0, 0);
    chk("R5 no overrun yet", {7'd0, overrun}, 8'd0);
    pulse_start();
    chk("R5 overrun set", {7'd0, overrun}, 8'd1);
    push(8'hEE, 0, 0, 0);
    chk("R5 head unchanged", rd_data, 8'hAA);
    pop(); chk("R5 head", rd_data, 8'hBB);
    pop(); chk("R5 head", rd_data, 8'hCC);
    pop(); chk("R5 replaced char", rd_data, 8'hEE);
    pop(); chk("R5 empty", {7'd0, ready}, 8'd0);
    chk("R5 sticky", {7'd0, overrun}, 8'd1);
    pulse_clr();
    chk("R5 cleared", {7'd0, overrun}, 8'd0);

    // R6 per-character status
    push(8'h01, 1, 0, 0); push(8'h02, 0, 1, 0);
    chk("R6 head flags", {5'd0, st_rb, st_fe, st_pe}, 8'd1);
    pop();
    chk("R6 next flags", {5'd0, st_rb, st_fe, st_pe}, 8'd2);
    pop();
    chk("R6 empty flags", {5'd0, st_rb, st_fe, st_pe}, 8'd0);

    // R7 block accumulation
    block_mode = 1;
    pulse_clr();
    chk("R7 after clear", {5'd0, st_rb, st_fe, st_pe}, 8'd0);
    push(8'h03, 1, 0, 0);
    chk("R7 first", {5'd0, st_rb, st_fe, st_pe}, 8'd1);
    push(8'h04, 0, 1, 0);
    chk("R7 second not at head", {5'd0, st_rb, st_fe, st_pe}, 8'd1);
    pop();
    chk("R7 or", {5'd0, st_rb, st_fe, st_pe}, 8'd3);
    pop();
    chk("R7 kept when empty", {5'd0, st_rb, st_fe, st_pe}, 8'd3);
    pulse_clr();
    chk("R7 clear", {5'd0, st_rb, st_fe, st_pe}, 8'd0);
    block_mode = 0;

    // R8 request select
    push(8'h06, 0, 0, 0);
    chk("R8 req ready", {7'd0, req}, 8'd1);
    irq_sel_full = 1; #1;
    chk("R8 req full sel", {7'd0, req}, 8'd0);
    push(8'h07, 0, 0, 0); push(8'h08, 0, 0, 0);
    chk("R8 req when full", {7'd0, req}, 8'd1);
    irq_sel_full = 0;
    pop(); pop(); pop();
    chk("R8 req empty", {7'd0, req}, 8'd0);

    // R9 automatic RTS
    auto_rts = 1; tick();
    chk("R9 rts idle", {7'd0, rts}, 8'd1);
    push(8'h21, 0, 0, 0); push(8'h22, 0, 0, 0); push(8'h23, 0, 0, 0);
    pulse_start();
    chk("R9 rts dropped", {7'd0, rts}, 8'd0);
    pop();
    chk("R9 rts still low", {7'd0, rts}, 8'd0);
    tick();
    chk("R9 rts back", {7'd0, rts}, 8'd1);
    pop(); pop();
    auto_rts = 0;
    push(8'h31, 0, 0, 0); push(8'h32, 0, 0, 0); push(8'h33, 0, 0, 0);
    pulse_start();
    chk("R9 rts off mode", {7'd0, rts}, 8'd1);

    // R10 disabled receiver
    cmd_disable = 1; tick(); cmd_disable = 0;
    push(8'h09, 0, 0, 0);
    pop();
    chk("R10 no char waited", {7'd0, full}, 8'd0);
    chk("R10 read still works", rd_data, 8'h32);
    pop(); pop();
    push(8'h0A, 0, 0, 0);
    chk("R10 ignored when empty", {7'd0, ready}, 8'd0);

    // R12 receiver reset
    enable();
    auto_rts = 1;
    push(8'h41, 0, 0, 1); push(8'h42, 0, 0, 0); push(8'h43, 0, 0, 0);
    push(8'h44, 0, 0, 0);
    pulse_start();
    chk("R12 pre overrun", {7'd0, overrun}, 8'd1);
    chk("R12 pre break flag", {7'd0, st_rb}, 8'd1);
    rx_rst = 1; tick(); rx_rst = 0;
    chk("R12 ready", {7'd0, ready}, 8'd0);
    chk("R12 full", {7'd0, full}, 8'd0);
    chk("R12 overrun", {7'd0, overrun}, 8'd0);
    chk("R12 rts", {7'd0, rts}, 8'd1);
    chk("R12 flags", {5'd0, st_rb, st_fe, st_pe}, 8'd0);
    push(8'h45, 0, 0, 0);
    chk("R12 off after reset", {7'd0, ready}, 8'd0);
    enable();
    push(8'h46, 0, 0, 0);
    chk("R12 re-enabled", rd_data, 8'h46);

    done = 1;
    summary();
    $finish;
  end
endmodule